// File: doc/BRIEF.md
# Dual-Channel Fast-Start Boxcar Averager

This block smooths two independent streams of 12-bit signed converter samples. Each channel keeps a running boxcar average over its most recent 256 samples. A running sum changes only on cycles where the shared sample strobe is accepted. The new sample is added. Once the window is full, the sample it overwrites is subtracted. The system clock runs far faster than the sample rate, so a result can take several clocks to compute and still be ready long before the next sample.

Right after reset the window is not yet full. During that period the sum is divided by the number of samples taken so far, not by 256. A constant input therefore shows at the output from the first sample on, with no slow climb from zero. Once 256 samples have arrived, the divide becomes an arithmetic shift. Every result is rounded toward negative infinity. Each channel's average is driven as a signed value and again as a plain bit vector, and a one-cycle pulse marks each update.

Each channel runs a small state machine with three states. ST_IDLE waits for a strobe. An accepted strobe moves it to ST_UPDATE, which writes the ring and updates the sum. From ST_UPDATE the channel goes back to ST_IDLE, publishing sum >>> 8, when the window is full. Otherwise it starts a 20-step restoring divider and goes to ST_DIVIDE. ST_DIVIDE returns to ST_IDLE and publishes the floored quotient when the divider reports done.

Top module: `dual_boxcar_avg`

## Requirements
- R1: While reset is high, both averages and both bit-vector outputs become zero and `avg_valid` is low at the next clock edge.
- R2: The first sample after reset appears unchanged as that channel's average.
- R3: While n < 256 samples have been accepted since reset, a channel's average equals floor(sum of those n samples / n).
- R4: Once 256 or more samples have been accepted, a channel's average equals floor(sum of the latest 256 samples / 256). The oldest sample drops out of the window as each new one arrives.
- R5: Rounding is toward negative infinity for negative sums. For example, samples -1 then 0 give -1.
- R6: Channel B is averaged with the same rules as channel A, from its own samples only.
- R7: `avg_a_bits` and `avg_b_bits` carry the two's-complement bit patterns of `avg_a` and `avg_b`.
- R8: `avg_valid` pulses for exactly one cycle per accepted sample, and the averages hold their values between pulses. Take an accepted strobe at edge k. Its result is registered at edge k+1 when the window is full after that sample, and at edge k+22 otherwise.
- R9: A strobe that arrives while a result is still being computed is ignored. It does not enter either window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | One-cycle strobe: a new sample pair is present |
| sample_a | input | 12 | Channel A sample, signed |
| sample_b | input | 12 | Channel B sample, signed |
| avg_a | output | 12 | Channel A average, signed |
| avg_b | output | 12 | Channel B average, signed |
| avg_a_bits | output | 12 | Channel A average as a plain vector |
| avg_b_bits | output | 12 | Channel B average as a plain vector |
| avg_valid | output | 1 | One-cycle pulse when both averages update |

## Verification
The bench drives a strobe on a falling edge and then counts falling edges until `avg_valid` is seen. With a full window the result must appear at the second falling edge; while the window is filling it must appear at the twenty-third, because the divider adds twenty iterations plus start and publish cycles. The averages are compared only on that edge, and on the falling edge after it the bench checks that the pulse has dropped and the values are unchanged. The intrusion test places its extra strobe five edges into a divide, so it lands in ST_DIVIDE where the design must discard it.

// File: rtl/boxcar_pkg.sv
package boxcar_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_UPDATE,
        ST_DIVIDE
    } chan_state_t;

    // cycles from an accepted strobe to the end of the slowest result
    function automatic int worst_latency(input int dividend_w);
        return dividend_w + 4;
    endfunction

endpackage

// File: rtl/boxcar_ring.sv
module boxcar_ring #(
    parameter int SAMPLE_W = 12,
    parameter int WIN_LOG2 = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic signed [SAMPLE_W-1:0]  wr_data,
    output logic signed [SAMPLE_W-1:0]  old_data,
    output logic [WIN_LOG2:0]           fill,
    output logic                        full
);
    localparam int DEPTH = 1 << WIN_LOG2;

    logic signed [SAMPLE_W-1:0] mem [DEPTH];
    logic [WIN_LOG2-1:0]        wptr;

    assign old_data = mem[wptr];
    assign full     = (fill == (WIN_LOG2+1)'(DEPTH));

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            fill <= '0;
        end else if (wr_en) begin
            wptr <= wptr + 1'b1;
            if (!full) begin
                fill <= fill + 1'b1;
            end
        end
    end

endmodule

// File: rtl/boxcar_divider.sv
module boxcar_divider #(
    parameter int DVD_W = 20,
    parameter int DVS_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic [DVD_W-1:0] quotient,
    output logic             done
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    logic [DVD_W-1:0] shreg;
    logic [DVS_W-1:0] rem;
    logic [DVS_W-1:0] dvs_q;
    logic [CNT_W-1:0] steps;
    logic [DVS_W:0]   trial;
    logic [DVS_W:0]   diff;

    assign trial    = {rem, shreg[DVD_W-1]};
    assign diff     = trial - {1'b0, dvs_q};
    assign quotient = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            rem   <= '0;
            dvs_q <= '0;
            steps <= '0;
            done  <= 1'b0;
        end else if (start) begin
            shreg <= dividend;
            rem   <= '0;
            dvs_q <= divisor;
            steps <= CNT_W'(DVD_W);
            done  <= 1'b0;
        end else if (steps != '0) begin
            if (trial >= {1'b0, dvs_q}) begin
                rem   <= diff[DVS_W-1:0];
                shreg <= {shreg[DVD_W-2:0], 1'b1};
            end else begin
                rem   <= trial[DVS_W-1:0];
                shreg <= {shreg[DVD_W-2:0], 1'b0};
            end
            steps <= steps - 1'b1;
            done  <= (steps == CNT_W'(1));
        end else begin
            done <= 1'b0;
        end
    end

endmodule

// File: rtl/boxcar_channel.sv
module boxcar_channel
    import boxcar_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int WIN_LOG2 = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] sample,
    output logic signed [SAMPLE_W-1:0] avg,
    output logic                       avg_valid
);
    localparam int SUM_W = SAMPLE_W + WIN_LOG2;
    localparam int CNT_W = WIN_LOG2 + 1;

    chan_state_t state, state_nx;

    logic                       accept;
    logic signed [SAMPLE_W-1:0] old_data;
    logic [CNT_W-1:0]           fill;
    logic                       full;
    logic signed [SUM_W-1:0]    sum;
    logic                       neg;
    logic [SUM_W-1:0]           dividend;
    logic                       div_start;
    logic [SUM_W-1:0]           quot;
    logic                       div_done;

    assign accept    = (state == ST_IDLE) && sample_valid;
    assign div_start = (state == ST_UPDATE) && !full;
    assign neg       = sum[SUM_W-1];
    // floor for negative sums: magnitude rounded up, then negated
    assign dividend  = neg ? (SUM_W'(-sum) + SUM_W'(fill) - SUM_W'(1))
                           : SUM_W'(sum);

    boxcar_ring #(
        .SAMPLE_W (SAMPLE_W),
        .WIN_LOG2 (WIN_LOG2)
    ) u_ring (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (accept),
        .wr_data  (sample),
        .old_data (old_data),
        .fill     (fill),
        .full     (full)
    );

    boxcar_divider #(
        .DVD_W (SUM_W),
        .DVS_W (CNT_W)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (div_start),
        .dividend (dividend),
        .divisor  (fill),
        .quotient (quot),
        .done     (div_done)
    );

    // running sum: add newest, drop overwritten slot once window is full
    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
        end else if (accept) begin
            sum <= sum + SUM_W'(sample) - (full ? SUM_W'(old_data) : SUM_W'(0));
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = ST_UPDATE;
            ST_UPDATE: state_nx = full ? ST_IDLE : ST_DIVIDE;
            ST_DIVIDE: if (div_done) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            avg       <= '0;
            avg_valid <= 1'b0;
        end else begin
            avg_valid <= 1'b0;
            unique case (state)
                ST_UPDATE: begin
                    if (full) begin
                        avg       <= SAMPLE_W'(sum >>> WIN_LOG2);
                        avg_valid <= 1'b1;
                    end
                end
                ST_DIVIDE: begin
                    if (div_done) begin
                        avg       <= SAMPLE_W'(neg ? -quot : quot);
                        avg_valid <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dual_boxcar_avg.sv
module dual_boxcar_avg #(
    parameter int SAMPLE_W = 12,
    parameter int WIN_LOG2 = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sample_valid,
    input  logic signed [SAMPLE_W-1:0] sample_a,
    input  logic signed [SAMPLE_W-1:0] sample_b,
    output logic signed [SAMPLE_W-1:0] avg_a,
    output logic signed [SAMPLE_W-1:0] avg_b,
    output logic [SAMPLE_W-1:0]        avg_a_bits,
    output logic [SAMPLE_W-1:0]        avg_b_bits,
    output logic                       avg_valid
);
    localparam int NUM_CH = 2;

    logic signed [SAMPLE_W-1:0] avg_arr [NUM_CH];
    logic [NUM_CH-1:0]          vld;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        boxcar_channel #(
            .SAMPLE_W (SAMPLE_W),
            .WIN_LOG2 (WIN_LOG2)
        ) u_chan (
            .clk          (clk),
            .rst          (rst),
            .sample_valid (sample_valid),
            .sample       ((ch == 0) ? sample_a : sample_b),
            .avg          (avg_arr[ch]),
            .avg_valid    (vld[ch])
        );
    end

    assign avg_a      = avg_arr[0];
    assign avg_b      = avg_arr[1];
    assign avg_a_bits = avg_arr[0];
    assign avg_b_bits = avg_arr[1];
    assign avg_valid  = &vld;

endmodule

// File: rtl/boxcar_checker.sv
module boxcar_checker #(
    parameter int SAMPLE_W = 12,
    parameter int MAX_LAT  = 24
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       sample_valid,
    input logic signed [SAMPLE_W-1:0] avg_a,
    input logic signed [SAMPLE_W-1:0] avg_b,
    input logic                       avg_valid
);
    localparam int LAT_W = $clog2(MAX_LAT + 2);

    logic             pending;
    logic [LAT_W-1:0] lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            lat     <= '0;
        end else if (avg_valid) begin
            pending <= sample_valid;
            lat     <= '0;
        end else if (!pending && sample_valid) begin
            pending <= 1'b1;
            lat     <= '0;
        end else if (pending && lat < LAT_W'(MAX_LAT + 1)) begin
            lat <= lat + 1'b1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (avg_a == '0 && avg_b == '0 && !avg_valid));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        avg_valid |=> !avg_valid);

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        (!avg_valid && !$past(rst)) |-> ($stable(avg_a) && $stable(avg_b)));

    // R8
    latency_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pending |-> (lat < LAT_W'(MAX_LAT)));

endmodule

bind dual_boxcar_avg boxcar_checker #(
    .SAMPLE_W (SAMPLE_W),
    .MAX_LAT  (boxcar_pkg::worst_latency(SAMPLE_W + WIN_LOG2))
) u_boxcar_checker (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .avg_a        (avg_a),
    .avg_b        (avg_b),
    .avg_valid    (avg_valid)
);

// File: tb/test_dual_boxcar_avg.sv
module test_dual_boxcar_avg;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sample_valid = 1'b0;
    logic signed [11:0] sample_a = '0;
    logic signed [11:0] sample_b = '0;
    logic signed [11:0] avg_a, avg_b;
    logic [11:0]        avg_a_bits, avg_b_bits;
    logic               avg_valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    int ha [256];
    int hb [256];
    int m_count;
    int m_wp;

    always #4 clk = ~clk;

    dual_boxcar_avg i_dual_boxcar_avg (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .sample_a     (sample_a),
        .sample_b     (sample_b),
        .avg_a        (avg_a),
        .avg_b        (avg_b),
        .avg_a_bits   (avg_a_bits),
        .avg_b_bits   (avg_b_bits),
        .avg_valid    (avg_valid)
    );

    function automatic int floor_div(input int s, input int n);
        int q;
        q = s / n;
        if ((s % n) != 0 && s < 0) q = q - 1;
        return q;
    endfunction

    function automatic int model_avg(input bit chan_b);
        int s;
        s = 0;
        for (int k = 0; k < m_count; k++) s += chan_b ? hb[k] : ha[k];
        return floor_div(s, m_count);
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sample_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_count = 0;
        m_wp = 0;
        // R1: cleared outputs right after reset
        check("R1 avg_a", int'(avg_a), 0);
        check("R1 avg_b", int'(avg_b), 0);
        check("R1 bits", int'(avg_a_bits) + int'(avg_b_bits), 0);
        check("R1 valid", int'(avg_valid), 0);
    endtask

    // tag_a names the requirement for channel A; channel B is tagged R6
    task automatic send(input int a, input int b, input bit intrude, input string tag_a);
        int lat;
        int exp_lat;
        int ea;
        int eb;
        @(negedge clk);
        sample_valid = 1'b1;
        sample_a = 12'(a);
        sample_b = 12'(b);
        ha[m_wp] = a;
        hb[m_wp] = b;
        m_wp = (m_wp + 1) % 256;
        if (m_count < 256) m_count++;
        exp_lat = (m_count == 256) ? 2 : 23;
        @(negedge clk);
        sample_valid = 1'b0;
        lat = 1;
        while (!avg_valid && lat < 100) begin
            if (intrude && lat == 5) begin
                // R9: this strobe must be discarded
                sample_valid = 1'b1;
                sample_a = 12'sd2047;
                sample_b = -12'sd2048;
            end else begin
                sample_valid = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        sample_valid = 1'b0;
        ea = model_avg(1'b0);
        eb = model_avg(1'b1);
        check("R8 latency", lat, exp_lat);
        check(tag_a, int'(avg_a), ea);
        check("R6 chan_b", int'(avg_b), eb);
        check("R7 bits_a", int'($signed(avg_a_bits)), ea);
        check("R7 bits_b", int'($signed(avg_b_bits)), eb);
        @(negedge clk);
        check("R8 pulse_end", int'(avg_valid), 0);
        check("R8 hold", int'(avg_a), ea);
    endtask

    function automatic int rnd_sample(input int i);
        int r;
        r = int'($urandom_range(0, 4095)) - 2048;
        if ((i % 64) < 4) r = -2048;
        else if ((i % 64) < 8) r = 2047;
        return r;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        m_count = 0;
        m_wp = 0;
        do_reset();

        // R2: first sample shows at once
        send(100, -100, 1'b0, "R2 first");

        // R5: floor toward negative infinity
        do_reset();
        send(-1, 5, 1'b0, "R2 first_neg");
        send(0, 6, 1'b0, "R5 floor_half");
        send(0, 0, 1'b0, "R5 floor_third");
        send(-7, 3, 1'b0, "R5 floor_quarter");

        // R9: strobe during divide is ignored
        do_reset();
        send(10, 20, 1'b0, "R2 first");
        send(30, 40, 1'b1, "R9 intrude");
        send(50, 60, 1'b1, "R9 intrude");

        // R3 / R4: random fill past the window with wrap
        do_reset();
        for (int i = 0; i < 320; i++) begin
            send(rnd_sample(i), rnd_sample(i + 17), (i < 10) ? 1'b1 : 1'b0,
                 (m_count >= 255) ? "R4 full" : "R3 fill");
        end

        // R4: extremes across a full window
        do_reset();
        for (int i = 0; i < 260; i++) begin
            send((i < 200) ? -2048 : 2047, (i % 2 == 0) ? 2047 : -2048, 1'b0,
                 (m_count >= 255) ? "R4 extremes" : "R3 extremes");
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule